// File: doc/BRIEF.md
# Shared-Pin Serial ADC Readout Controller

This block reads results from a 24-bit delta-sigma converter that has only two digital wires: a serial clock driven by the host and one return line. The return line has two jobs. While the converter is busy, it is a ready flag that rests high and drops low when a result is available. After the first serial-clock rise, it carries the result instead.

The controller passes the return line through a two-flop synchronizer and waits in idle for a high-to-low transition. It then issues 24 serial-clock pulses and captures the bits most significant first. It sends a 25th pulse so that the line goes back high. The serial clock comes straight from a flop. Its high and low phases each last a programmable number of system clocks. The captured two's-complement word is presented with a single-cycle valid strobe.

While enabled and idle, the controller also counts how long it waits for a result. It raises a sticky timeout flag if the wait exceeds a programmable limit.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: During and right after reset, sclk_o is 0, valid_o is 0, word_o is 0 and timeout_o is 0.
- R2: A frame starts only while idle with en_i high, on a synchronized high-to-low transition of line_i. While en_i is low, a low line produces no serial-clock edge.
- R3: Every frame issues exactly 25 rising edges on sclk_o: 24 for the data bits and one extra to return the line high.
- R4: Each high phase and each low phase of sclk_o lasts H system clocks. H is half_div_i clamped to a minimum of 2, and it is sampled once when the frame starts, so later changes do not affect a running frame.
- R5: The line is sampled at the end of each of the first 24 serial-clock periods, just before the next rise. The first bit sampled is bit 23 of word_o (MSB first).
- R6: After the low phase that follows the 25th rise, word_o holds the captured word as two's complement and valid_o is 1 for exactly one system clock.
- R7: sclk_o stays low whenever the controller is idle, including between frames.
- R8: While idle with en_i high, a wait of more than tmo_lim_i system clocks without a frame start sets timeout_o. The flag holds until en_i is low, which clears it on the next clock. Normal frames arriving within the limit leave it at 0.
- R9: A line already low when the controller becomes enabled does not start a frame. The line must first be seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low clears the timeout flag |
| half_div_i | input | DIV_W (8) | Serial-clock half period in system clocks (min 2) |
| tmo_lim_i | input | TMO_W (20) | Idle wait limit in system clocks |
| line_i | input | 1 | Combined ready / serial data line from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| word_o | output | WORD_W (24) | Last captured result, two's complement |
| valid_o | output | 1 | One-cycle strobe when word_o updates |
| timeout_o | output | 1 | Sticky no-result flag |

## Verification
The bench models the converter. It drops the line after varied gaps, changes the line one time step after each serial-clock rise, and drives it high after the 25th rise.

The result words include:
- all-zeros and all-ones, which catch stuck or missing shifts;
- 800000 and 000001, which separate MSB-first from LSB-first order and catch off-by-one capture;
- 7FFFFF and the alternating patterns A5A5A5 and 5A5A5A, which expose early or late sampling;
- 123456, a pattern with no symmetry.

Divider values of 0 and 1 show the clamp, values of 3 to 7 show the scaling of the phase length, and a mid-frame divider change shows that the value is latched at frame start. Directed cases cover a line held low across enable, and the timeout flag both setting and clearing.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} rd_state_e;
endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o,
  output logic line_q_o
);
  logic meta_q, sync_q, prev_q;

  // idle level of the line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_s_o = sync_q;
  assign line_q_o = prev_q;
endmodule

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] h_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= h_i - DIV_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = (cnt_q == '0);

  p_reload_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && h_i >= DIV_W'(2)) |=> !tick_o);
endmodule

// File: rtl/adc_idle_watch.sv
module adc_idle_watch #(
  parameter int TMO_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             idle_i,
  input  logic             start_i,
  input  logic [TMO_W-1:0] lim_i,
  output logic             flag_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
    end else if (idle_i) begin
      if (cnt_q >= lim_i) flag_q <= 1'b1;
      else                cnt_q  <= cnt_q + TMO_W'(1);
    end
  end

  assign flag_o = flag_q;

  p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !flag_o);
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && en_i) |=> flag_o);
endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
  import adc_rdout_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  input  logic              line_i,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              timeout_o
);
  localparam int               CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] NDATA = CNT_W'(WORD_W);

  rd_state_e         state_q;
  logic              line_s, line_q;
  logic              start, tick, load, last_end;
  logic [DIV_W-1:0]  h_eff, h_q, h_tmr;
  logic [CNT_W-1:0]  pulse_q;
  logic [WORD_W-1:0] shreg_q;
  logic              sclk_q;

  adc_line_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .line_s_o(line_s),
    .line_q_o(line_q)
  );

  assign h_eff    = (half_div_i < DIV_W'(2)) ? DIV_W'(2) : half_div_i;
  assign start    = (state_q == ST_IDLE) && en_i && !line_s && line_q;
  assign last_end = (state_q == ST_RUN) && tick && !sclk_q && (pulse_q == LAST);
  assign load     = start || ((state_q == ST_RUN) && tick && !last_end);
  assign h_tmr    = start ? h_eff : h_q;

  adc_half_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .h_i   (h_tmr),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      pulse_q <= '0;
      h_q     <= DIV_W'(2);
      shreg_q <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          sclk_q  <= 1'b1;
          pulse_q <= CNT_W'(1);
          h_q     <= h_eff;
        end
        ST_RUN: if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
          end else begin
            // end of period: line settled after the rising edge
            if (pulse_q <= NDATA) shreg_q <= {shreg_q[WORD_W-2:0], line_s};
            if (pulse_q == LAST) begin
              state_q <= ST_IDLE;
              word_o  <= shreg_q;
              valid_o <= 1'b1;
            end else begin
              sclk_q  <= 1'b1;
              pulse_q <= pulse_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;

  adc_idle_watch #(.TMO_W(TMO_W)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .idle_i (state_q == ST_IDLE),
    .start_i(start),
    .lim_i  (tmo_lim_i),
    .flag_o (timeout_o)
  );

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_sclk_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sclk_o);
  p_pulse_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q <= LAST);
  p_start_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RUN) |-> $past(en_i));
  p_half_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (h_q >= DIV_W'(2)));
  p_h_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN) && $past(state_q == ST_RUN)) |-> $stable(h_q));
endmodule

// File: tb/adc_rdout_ctrl_tb_top.sv
module adc_rdout_ctrl_tb_top;
  localparam int NV = 8;
  localparam logic [23:0] PAT [NV] = '{24'h800000, 24'h000001, 24'h7FFFFF, 24'hFFFFFF,
                                       24'hA5A5A5, 24'h5A5A5A, 24'h123456, 24'h000000};
  localparam int DIV [NV] = '{2, 3, 0, 1, 5, 4, 7, 3};
  localparam int GAP [NV] = '{6, 11, 8, 23, 5, 14, 9, 17};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  half_div_i = 8'd2;
  logic [19:0] tmo_lim_i = 20'hFFFFF;
  logic        line_i = 1'b1;
  logic        sclk_o, valid_o, timeout_o;
  logic [23:0] word_o;

  int n_chk = 0, n_bad = 0;
  int edges = 0, hi_cyc = 0;

  always #2 clk_i = ~clk_i;

  adc_rdout_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .half_div_i(half_div_i),
    .tmo_lim_i(tmo_lim_i), .line_i(line_i), .sclk_o(sclk_o), .word_o(word_o),
    .valid_o(valid_o), .timeout_o(timeout_o)
  );

  always @(posedge sclk_o) edges++;
  always @(posedge clk_i) if (sclk_o) hi_cyc++;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // converter model; div changes to mid_div after the 3rd rise
  task automatic run_frame(input logic [23:0] w, input int gap, input int mid_div);
    repeat (gap) @(negedge clk_i);
    edges = 0; hi_cyc = 0;
    line_i = 1'b0;
    for (int k = 0; k < 25; k++) begin
      @(posedge sclk_o);
      #1;
      line_i = (k < 24) ? w[23-k] : 1'b1;
      if (k == 2) half_div_i = 8'(mid_div);
    end
    for (int t = 0; t < 200 && !valid_o; t++) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 sclk", 32'(sclk_o), 0);
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 word", 32'(word_o), 0);
    chk("R1 timeout", 32'(timeout_o), 0);
    rst_ni = 1'b1;

    // R2 / R9: line low while disabled, then enabled while still low
    @(negedge clk_i);
    line_i = 1'b0; edges = 0;
    repeat (40) @(negedge clk_i);
    chk("R2 no clocks while disabled", 32'(edges), 0);
    en_i = 1'b1;
    repeat (40) @(negedge clk_i);
    chk("R9 low line at enable ignored", 32'(edges), 0);
    line_i = 1'b1;
    repeat (6) @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      int h;
      h = (DIV[v] < 2) ? 2 : DIV[v];
      half_div_i = 8'(DIV[v]);
      run_frame(PAT[v], GAP[v], DIV[v]);
      chk("R6 valid seen", 32'(valid_o), 1);
      chk("R5 word", 32'(word_o), 32'(PAT[v]));
      chk("R3 edges", 32'(edges), 25);
      chk("R4 high cycles", 32'(hi_cyc), 32'(25 * h));
      @(negedge clk_i);
      chk("R6 one-cycle valid", 32'(valid_o), 0);
      chk("R7 sclk idle", 32'(sclk_o), 0);
    end
    chk("R8 no timeout in normal use", 32'(timeout_o), 0);

    // R4: divider change mid-frame ignored
    half_div_i = 8'd3;
    run_frame(24'h3C0F96, 7, 9);
    chk("R4 latched div word", 32'(word_o), 32'h3C0F96);
    chk("R4 latched div high cycles", 32'(hi_cyc), 32'(25 * 3));
    chk("R3 edges latched", 32'(edges), 25);

    // R8: timeout set and clear
    repeat (4) @(negedge clk_i);
    tmo_lim_i = 20'd50;
    repeat (30) @(negedge clk_i);
    chk("R8 not yet", 32'(timeout_o), 0);
    repeat (40) @(negedge clk_i);
    chk("R8 set", 32'(timeout_o), 1);
    repeat (10) @(negedge clk_i);
    chk("R8 sticky", 32'(timeout_o), 1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R8 cleared", 32'(timeout_o), 0);
    chk("R7 sclk idle at end", 32'(sclk_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule